// File: doc/BRIEF.md
# Serial Nonvolatile SRAM Command Slave

This block is a serial-bus slave that behaves like a small nonvolatile static RAM holding sixteen 16-bit words. A host selects it with an active-low chip-select and clocks it in SPI mode 0: data is sampled on the rising edge of the serial clock and driven on the falling edge. Every transaction begins with one instruction byte, which carries both the command and a 4-bit word address. Reads and writes then move one 16-bit word, sending the high byte first and the most significant bit first.

The block keeps two copies of the array. The volatile copy is what reads and writes use. The shadow copy stands in for the nonvolatile cells: a store command copies the whole volatile array into it, and a recall command copies it back. A write-enable latch guards writes and stores. A sleep flag makes the block ignore every command except recall.

All pins are sampled into the system clock domain through two-flop synchronizers. Commands take effect when chip-select rises again.

Top module: `nvsram_serial`

## Requirements
- R1: The instruction's bit 7 must be 1 for any command to be recognised. With bit 7 at 0 the transaction has no effect: no write, no state change, and miso stays low. For recognised bytes, bits 2..0 pick the command: 0 write disable, 1 store, 2 sleep, 3 write, 4 write enable, 5 recall, 6 and 7 read.
- R2: Instruction bits 6..3 give the word address (0..15). Each address selects its own word.
- R3: A write-enable latch is set by command 4, cleared by command 0, and cleared by reset. A write issued while the latch is clear changes nothing.
- R4: A write (command 3) takes a 16-bit word made of the two bytes after the instruction, high byte first and MSB first. The word is stored in the addressed volatile word when chip-select rises, but only if exactly 24 serial clocks were received.
- R5: A read (command 6 or 7) drives the addressed word on miso, MSB first. The first bit is valid before the first rising serial clock after the instruction, and each following bit changes on a falling edge.
- R6: miso is low whenever the block is not selected.
- R7: Store (command 1) copies all sixteen volatile words into the shadow array, and only while the write-enable latch is set.
- R8: Recall (command 5) copies all sixteen shadow words into the volatile array and does not need the write-enable latch. Reset does not clear the shadow array.
- R9: Sleep (command 2) sets a flag. While the flag is set, every command other than recall is ignored and reads drive zeros. A recall runs normally and clears the flag.
- R10: The single-byte commands (0, 1, 2, 4, 5) act only when exactly 8 serial clocks were received in the transaction.
- R11: Reset clears the volatile array, the sleep flag and the write-enable latch, and leaves miso low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select that frames a transaction |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, low when not selected |

## Verification
The bench targets the framing rules. It sends transactions that stop after one data byte, that run four bits past the word, that carry extra bytes after a single-byte command, and that have bit 7 cleared. A design that counted bytes loosely, or ignored bit 7, would commit a corrupted word or act on a malformed command, and the read-back would show it. Both read opcodes are exercised, as are the first and last addresses. A design that mis-sliced the address field, or was late loading the first output bit, would return a shifted or misplaced word. Store while write-disabled, store and write-disable sent during sleep, and recall after a mid-run reset are each followed by a recall and a read. A design that gated these commands wrongly, or that reset the shadow array, would return a value other than the one the requirements predict.

// File: rtl/nvs_pkg.sv
// Package nvs_pkg
// Shared constants and the command decoder for the serial NV SRAM slave.
// Assumes an 8-bit instruction whose bit 7 marks a valid command.
package nvs_pkg;

    localparam int INSTR_W  = 8;
    localparam int ADDR_LSB = 3;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOCK,
        OP_SAVE,
        OP_DOZE,
        OP_WRITE,
        OP_UNLOCK,
        OP_RESTORE,
        OP_READ
    } op_e;

    // Turn a received instruction byte into a command.
    function automatic op_e decode_op(input logic [INSTR_W-1:0] b);
        op_e r;
        if (!b[INSTR_W-1]) begin
            r = OP_NONE;
        end else begin
            case (b[2:0])
                3'd0:    r = OP_LOCK;
                3'd1:    r = OP_SAVE;
                3'd2:    r = OP_DOZE;
                3'd3:    r = OP_WRITE;
                3'd4:    r = OP_UNLOCK;
                3'd5:    r = OP_RESTORE;
                default: r = OP_READ;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/nvs_sync.sv
// Module nvs_sync
// Brings the asynchronous serial pins into the clk domain and produces
// single-cycle edge pulses. Assumes clk runs several times faster than sclk.
// mosi goes through the same number of stages as sclk so the two stay aligned.
module nvs_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic mosi_i,
    output logic cs_act,
    output logic cs_start,
    output logic cs_end,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);

    logic [2:0] cs_p;
    logic [2:0] ck_p;
    logic [1:0] di_p;

    // Shift the pins through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p <= '1;
            ck_p <= '0;
            di_p <= '0;
        end else begin
            cs_p <= {cs_p[1:0], cs_n_i};
            ck_p <= {ck_p[1:0], sclk_i};
            di_p <= {di_p[0], mosi_i};
        end
    end

    assign cs_act    = !cs_p[1];
    assign cs_start  = !cs_p[1] &&  cs_p[2];
    assign cs_end    =  cs_p[1] && !cs_p[2];
    assign sclk_rise =  ck_p[1] && !ck_p[2];
    assign sclk_fall = !ck_p[1] &&  ck_p[2];
    assign mosi_s    =  di_p[1];

endmodule

// File: rtl/nvs_shift.sv
// Module nvs_shift
// Bit and byte counting, instruction capture, receive shift register and
// the transmit shifter. Assumes edge pulses from nvs_sync. It loads the
// read word on the falling edge that follows the eighth rising edge.
module nvs_shift #(
    parameter int DATA_W  = 16,
    parameter int BYTE_CW = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_act,
    input  logic                       cs_start,
    input  logic                       sclk_rise,
    input  logic                       sclk_fall,
    input  logic                       mosi_s,
    input  logic                       tx_allow,
    input  logic [DATA_W-1:0]          tx_word,
    output logic [nvs_pkg::INSTR_W-1:0] instr,
    output logic [DATA_W-1:0]          rx_data,
    output logic [2:0]                 bit_cnt,
    output logic [BYTE_CW-1:0]         byte_cnt,
    output logic                       miso
);

    localparam int BYTE_MAX = (1 << BYTE_CW) - 1;

    logic [DATA_W-1:0] tx_q;
    logic              tx_on;
    logic              load_pend;

    // Count bits and bytes, and capture the instruction and data bits.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_start) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            instr    <= '0;
            rx_data  <= '0;
        end else if (cs_act && sclk_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7 && byte_cnt != BYTE_CW'(BYTE_MAX))
                byte_cnt <= byte_cnt + 1'b1;
            if (byte_cnt == '0)
                instr <= {instr[nvs_pkg::INSTR_W-2:0], mosi_s};
            else
                rx_data <= {rx_data[DATA_W-2:0], mosi_s};
        end
    end

    // Load the read word after the instruction, then shift on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q      <= '0;
            tx_on     <= 1'b0;
            load_pend <= 1'b0;
        end else if (cs_start || !cs_act) begin
            tx_on     <= 1'b0;
            load_pend <= 1'b0;
        end else begin
            if (sclk_rise && byte_cnt == '0 && bit_cnt == 3'd7)
                load_pend <= 1'b1;
            if (sclk_fall) begin
                if (load_pend) begin
                    load_pend <= 1'b0;
                    tx_on     <= tx_allow;
                    tx_q      <= tx_word;
                end else if (tx_on) begin
                    tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = tx_on && tx_q[DATA_W-1];

    // R4: a new selection starts counting from zero
    p_count_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start |=> (bit_cnt == '0 && byte_cnt == '0));

    // R6: the transmitter is off the cycle after deselection
    p_tx_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !tx_on);

endmodule

// File: rtl/nvs_array.sv
// Module nvs_array
// Volatile word array plus a shadow copy. The volatile side resets to zero.
// The shadow side has no reset, so its contents survive reset.
// Assumes the write, save and restore strobes are single-cycle and never coincide.
module nvs_array #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              save_en,
    input  logic              restore_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int WORDS = 1 << ADDR_W;

    logic [WORDS-1:0][DATA_W-1:0] vol_q;
    logic [WORDS-1:0][DATA_W-1:0] shd_q;

    // Volatile array: cleared by reset, written per word or loaded from the shadow.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vol_q <= '0;
        else if (restore_en)
            vol_q <= shd_q;
        else if (wr_en)
            vol_q[wr_addr] <= wr_data;
    end

    // Shadow array: takes a full copy of the volatile array on a save.
    always_ff @(posedge clk) begin
        if (save_en)
            shd_q <= vol_q;
    end

    assign rd_data = vol_q[rd_addr];

    // R7: at most one array action per cycle
    p_single_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, save_en, restore_en}));

    // R7: a save mirrors the whole volatile array
    p_save_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> (shd_q == $past(vol_q)));

    // R8: a restore brings back the whole shadow array
    p_restore_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> (vol_q == $past(shd_q)));

    // R4: a committed write lands in the addressed word
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vol_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/nvsram_serial.sv
// Module nvsram_serial
// Top level of the serial NV SRAM slave. It holds the write-enable latch
// and the sleep flag, decodes the captured instruction, and issues the
// commit strobes when chip-select rises. Assumes clk is at least 8x sclk.
module nvsram_serial #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4,
    parameter int BYTE_CW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso
);

    import nvs_pkg::*;

    localparam int DATA_BYTES = DATA_W / 8;
    localparam int FULL_BYTES = 1 + DATA_BYTES;

    logic                  cs_act, cs_start, cs_end, sclk_rise, sclk_fall, mosi_s;
    logic [INSTR_W-1:0]    instr;
    logic [DATA_W-1:0]     rx_data;
    logic [DATA_W-1:0]     rd_data;
    logic [2:0]            bit_cnt;
    logic [BYTE_CW-1:0]    byte_cnt;
    logic [ADDR_W-1:0]     addr;
    op_e                   op;
    logic                  simple, full;
    logic                  wel, doze;
    logic                  wr_en, save_en, restore_en, tx_allow;

    nvs_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_n),
        .sclk_i    (sclk),
        .mosi_i    (mosi),
        .cs_act    (cs_act),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s)
    );

    nvs_shift #(.DATA_W(DATA_W), .BYTE_CW(BYTE_CW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .cs_start  (cs_start),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .tx_allow  (tx_allow),
        .tx_word   (rd_data),
        .instr     (instr),
        .rx_data   (rx_data),
        .bit_cnt   (bit_cnt),
        .byte_cnt  (byte_cnt),
        .miso      (miso)
    );

    nvs_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (addr),
        .wr_data    (rx_data),
        .save_en    (save_en),
        .restore_en (restore_en),
        .rd_addr    (addr),
        .rd_data    (rd_data)
    );

    // Decode the instruction and classify the transaction length.
    always_comb begin
        op     = decode_op(instr);
        addr   = instr[ADDR_LSB +: ADDR_W];
        simple = (byte_cnt == BYTE_CW'(1))          && (bit_cnt == 3'd0);
        full   = (byte_cnt == BYTE_CW'(FULL_BYTES)) && (bit_cnt == 3'd0);
    end

    // Commit strobes, issued on the cycle chip-select is seen to rise.
    assign wr_en      = cs_end && !doze && wel && (op == OP_WRITE) && full;
    assign save_en    = cs_end && !doze && wel && (op == OP_SAVE)  && simple;
    assign restore_en = cs_end && (op == OP_RESTORE) && simple;
    assign tx_allow   = (op == OP_READ) && !doze;

    // Write-enable latch and sleep flag, updated by single-byte commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            doze <= 1'b0;
        end else if (cs_end && simple) begin
            if (doze) begin
                if (op == OP_RESTORE)
                    doze <= 1'b0;
            end else begin
                case (op)
                    OP_LOCK:   wel  <= 1'b0;
                    OP_UNLOCK: wel  <= 1'b1;
                    OP_DOZE:   doze <= 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    // R6: miso quiet once deselection has passed the synchronizer
    p_miso_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

    // R3: a well-formed write disable clears the latch
    p_lock_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_end && simple && !doze && op == OP_LOCK) |=> !wel);

    // R9: the latch cannot move while asleep
    p_doze_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        doze |=> $stable(wel));

endmodule

// File: tb/nvsram_serial_test.sv
// Bench for nvsram_serial: a vector table walked by one loop, then directed
// reset checks. Each vector is one transaction; reads are checked against
// the expected word.
module nvsram_serial_test;

    localparam int HALF = 6;

    typedef struct packed {
        logic [7:0]  ins;
        logic [4:0]  nb;
        logic [23:0] dat;
        logic        chk;
        logic [15:0] exp;
        logic [3:0]  req;
    } row_t;

    localparam int NV = 48;
    localparam row_t VEC [NV] = '{
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h0000, 4'd11}, // R11 reset zero
        '{8'hAB, 5'd16, 24'h123400, 1'b0, 16'h0000, 4'd3 }, // R3 write while locked
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h0000, 4'd3 },
        '{8'h84, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd3 }, // unlock
        '{8'hAB, 5'd16, 24'h123400, 1'b0, 16'h0000, 4'd4 },
        '{8'hAF, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd5 }, // R5 alias read
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd5 },
        '{8'hFB, 5'd16, 24'hBEEF00, 1'b0, 16'h0000, 4'd2 },
        '{8'hFE, 5'd16, 24'h000000, 1'b1, 16'hBEEF, 4'd2 }, // R2 address 15
        '{8'h86, 5'd16, 24'h000000, 1'b1, 16'h0000, 4'd2 }, // R2 address 0
        '{8'hAB, 5'd8,  24'h555500, 1'b0, 16'h0000, 4'd4 }, // R4 one data byte
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd4 },
        '{8'hAB, 5'd20, 24'h555550, 1'b0, 16'h0000, 4'd4 }, // R4 20 data bits
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd4 },
        '{8'h2B, 5'd16, 24'h777700, 1'b0, 16'h0000, 4'd1 }, // R1 bit 7 clear
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd1 },
        '{8'h2E, 5'd16, 24'h000000, 1'b1, 16'h0000, 4'd1 }, // R1 read, bit 7 clear
        '{8'h81, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd7 }, // store
        '{8'hAB, 5'd16, 24'h999900, 1'b0, 16'h0000, 4'd4 },
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h9999, 4'd4 },
        '{8'h85, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd8 }, // recall
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd8 },
        '{8'hFE, 5'd16, 24'h000000, 1'b1, 16'hBEEF, 4'd8 },
        '{8'h80, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd3 }, // lock
        '{8'hAB, 5'd16, 24'h444400, 1'b0, 16'h0000, 4'd3 },
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd3 },
        '{8'h84, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd7 },
        '{8'hAB, 5'd16, 24'h444400, 1'b0, 16'h0000, 4'd7 },
        '{8'h80, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd7 },
        '{8'h81, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd7 }, // R7 store while locked
        '{8'h85, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd7 },
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd7 },
        '{8'h84, 5'd8,  24'h000000, 1'b0, 16'h0000, 4'd10}, // R10 unlock + extra byte
        '{8'hAB, 5'd16, 24'h555500, 1'b0, 16'h0000, 4'd10},
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd10},
        '{8'h84, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd9 },
        '{8'h82, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd9 }, // sleep
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h0000, 4'd9 }, // R9 read asleep
        '{8'h80, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd9 }, // lock ignored
        '{8'hAB, 5'd16, 24'h666600, 1'b0, 16'h0000, 4'd9 },
        '{8'h85, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd9 }, // wake
        '{8'hAB, 5'd16, 24'h666600, 1'b0, 16'h0000, 4'd9 },
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h6666, 4'd9 }, // R9 latch kept
        '{8'h82, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd9 },
        '{8'h81, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd9 }, // store ignored
        '{8'h85, 5'd0,  24'h000000, 1'b0, 16'h0000, 4'd9 },
        '{8'hAE, 5'd16, 24'h000000, 1'b1, 16'h1234, 4'd9 }, // R9 shadow kept
        '{8'hFE, 5'd16, 24'h000000, 1'b1, 16'hBEEF, 4'd2 }
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    nvsram_serial uut (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .mosi  (mosi),
        .miso  (miso)
    );

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] ins, input int nbits,
                        input logic [23:0] dat, output logic [15:0] rd);
        logic [31:0] stream;
        stream = {ins, dat};
        rd = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 8 + nbits; i++) begin
            mosi = stream[31-i];
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 24) rd = {rd[14:0], miso};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(miso == 1'b0, "R11", {15'd0, miso}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i].ins, int'(VEC[i].nb), VEC[i].dat, rd);
            if (VEC[i].chk)
                check(rd == VEC[i].exp, $sformatf("R%0d", VEC[i].req), rd, VEC[i].exp);
            // R6: deselected output is low
            check(miso == 1'b0, "R6", {15'd0, miso}, 16'h0000);
        end

        // R11: a mid-run reset clears the volatile array and the latch
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(miso == 1'b0, "R11", {15'd0, miso}, 16'h0000);
        xfer(8'hAE, 16, 24'h0, rd);
        check(rd == 16'h0000, "R11", rd, 16'h0000);
        xfer(8'hAB, 16, 24'h135700, rd);
        xfer(8'hAE, 16, 24'h0, rd);
        check(rd == 16'h0000, "R3", rd, 16'h0000);
        // R8: the shadow array survives reset
        xfer(8'h85, 0, 24'h0, rd);
        xfer(8'hAE, 16, 24'h0, rd);
        check(rd == 16'h1234, "R8", rd, 16'h1234);
        xfer(8'hFE, 16, 24'h0, rd);
        check(rd == 16'hBEEF, "R8", rd, 16'hBEEF);

        finish_run();
    end

endmodule